// File: doc/BRIEF.md
# Nibble-Loaded Accumulator Microprocessor

A very small 4-bit processor built around one accumulator. It executes 8-bit instructions. The high nibble of each instruction selects one of sixteen operations. The low nibble is either an immediate constant or an address in a sixteen-word, 4-bit data store. The processor also holds an index register, a zero flag and a carry flag, and it drives a registered 4-bit output port.

Programs are fed in one nibble at a time while `restart` is held high. Each rising edge of `enter` takes the nibble on `din`. Every instruction is sent as two nibbles, the opcode first and the operand second. One load holds at most ten instructions. When `restart` drops, the core runs from address 0, spending three clock cycles on each instruction (fetch, decode, execute). It stops at either of two instructions. `halt` stops the core for good, until the next restart. `rip` ends the current segment, so that the next segment can be loaded over it. Data memory, the accumulator, the index register and the flags are kept across restarts, so later segments can use results left by earlier ones.

Top module: `nibcore`

## Requirements
- R1: After `rst_n` is released, and before any program runs: `dout` is 0, `halted` is 0, `running` is 0, `zflag` is 1 and `cflag` is 0.
- R2: While `restart` is high, each 0-to-1 change of `enter` captures `din` exactly once, even if `enter` stays high for several cycles. The first nibble becomes instruction bits 7:4 and the second becomes bits 3:0. Instructions are stored at consecutive addresses starting from 0.
- R3: A single load stores at most 10 instructions. Any further instructions in the same load are discarded, and the program memory at address 10 and above keeps its previous contents.
- R4: One cycle after `restart` is seen high, `running` and `halted` are 0. This takes priority over an instruction that is in its execute cycle, and that instruction has no effect. Once `restart` falls, execution starts at address 0 and each instruction takes three cycles. Data memory, accumulator, index register and flags are kept across a restart.
- R5: The opcodes are 0000 halt, 0001 rip, 0010 wo, 0011 bnez, 0100 ld, 0101 st, 0111 ldx, 1000 addx, 1001 and, 1010 addi, 1111 sub. `addi k` sets acc to acc+k mod 16. `and k` sets acc to acc AND k. `ld a` sets acc to DM[a]. `st a` sets DM[a] to acc.
- R6: `sub a` sets acc to (DM[a] - acc) mod 16 and sets the carry flag to 1 exactly when DM[a] < acc. `addi` and `addx` set the carry flag to the carry out of the 4-bit sum.
- R7: `ldx a` loads the index register with DM[a]. `addx` sets acc to (DM[ix] + acc) mod 16.
- R8: `bnez t` jumps to address t when acc is nonzero. Otherwise execution continues at the next address.
- R9: `wo` copies acc to `dout`. `dout` changes on no other event.
- R10: `halt` sets `halted` and clears `running`. Both stay that way until `restart`.
- R11: `rip` clears `running` and leaves `halted` at 0. The core then waits for `restart`.
- R12: Opcodes 0110, 1011, 1100, 1101 and 1110 change nothing except advancing to the next instruction.
- R13: `zflag` equals (acc == 0) after every accumulator write. `ld` and `and` leave the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | High: load mode, program counter held at 0 |
| enter | input | 1 | Nibble strobe; the rising edge captures `din` |
| din | input | 4 | Program nibble |
| dout | output | 4 | Output port written by `wo` |
| halted | output | 1 | A `halt` has been executed |
| running | output | 1 | Core is in fetch, decode or execute |
| zflag | output | 1 | Zero flag |
| cflag | output | 1 | Carry / borrow flag |

## Verification
The collision of interest is `restart` arriving in the same cycle as an instruction's execute step. Restart must win, and the instruction must be dropped. The bench provokes this by letting a counting loop run and then raising `restart` at three different cycle offsets, so that it lands on each of the fetch, decode and execute phases. A behavioural model, updated on the same edges, judges every cycle against all five outputs. A later `wo` then shows whether the dropped instruction changed the accumulator.

// File: rtl/nibcore_pkg.sv
package nibcore_pkg;
    localparam int DW    = 4;
    localparam int AW    = 4;
    localparam int IW    = 2 * DW;
    localparam int DM_N  = 1 << AW;
    localparam int IM_N  = 1 << AW;

    localparam logic [3:0] OP_HALT = 4'b0000;
    localparam logic [3:0] OP_RIP  = 4'b0001;
    localparam logic [3:0] OP_WO   = 4'b0010;
    localparam logic [3:0] OP_BNEZ = 4'b0011;
    localparam logic [3:0] OP_LD   = 4'b0100;
    localparam logic [3:0] OP_ST   = 4'b0101;
    localparam logic [3:0] OP_LDX  = 4'b0111;
    localparam logic [3:0] OP_ADDX = 4'b1000;
    localparam logic [3:0] OP_AND  = 4'b1001;
    localparam logic [3:0] OP_ADDI = 4'b1010;
    localparam logic [3:0] OP_SUB  = 4'b1111;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_FETCH, S_DECODE, S_EXEC, S_STOP
    } state_e;

    typedef struct packed {
        state_e                      st;
        logic [AW-1:0]               pc;
        logic [IW-1:0]               ir;
        logic [DW-1:0]               opnd;
        logic [DW-1:0]               acc;
        logic [DW-1:0]               ix;
        logic [DW-1:0]               dout;
        logic                        z;
        logic                        c;
        logic                        halted;
        logic [DM_N-1:0][DW-1:0]     dm;
    } core_t;
endpackage

// File: rtl/nibcore_loader.sv
module nibcore_loader
    import nibcore_pkg::*;
#(
    parameter int SEG_LEN = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          enter,
    input  logic [DW-1:0] din,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [IW-1:0] wdata
);
    localparam int PW = $clog2(SEG_LEN + 1);

    typedef struct packed {
        logic          enter_q;
        logic          second;
        logic [DW-1:0] hi;
        logic [PW-1:0] ptr;
    } ld_t;

    ld_t ld_d, ld_q;
    logic strobe;

    always_comb begin
        ld_d         = ld_q;
        ld_d.enter_q = enter;
        strobe       = enter & ~ld_q.enter_q;
        we           = 1'b0;
        wdata        = {ld_q.hi, din};
        waddr        = AW'(ld_q.ptr);
        if (!restart) begin
            ld_d.second = 1'b0;
            ld_d.ptr    = '0;
        end else if (strobe) begin
            if (!ld_q.second) begin
                ld_d.hi     = din;
                ld_d.second = 1'b1;
            end else begin
                ld_d.second = 1'b0;
                if (ld_q.ptr < PW'(SEG_LEN)) begin
                    we       = 1'b1;
                    ld_d.ptr = ld_q.ptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    assert_write_only_loading_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> restart);
    assert_segment_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_q.ptr <= PW'(SEG_LEN));
endmodule

// File: rtl/nibcore_imem.sv
module nibcore_imem
    import nibcore_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    logic [IM_N-1:0][IW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/nibcore_alu.sv
module nibcore_alu
    import nibcore_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] mem,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          acc_we,
    output logic          c_we
);
    logic [DW:0] sum;

    always_comb begin
        res    = acc;
        cout   = 1'b0;
        acc_we = 1'b0;
        c_we   = 1'b0;
        sum    = '0;
        case (op)
            OP_LD: begin
                res    = mem;
                acc_we = 1'b1;
            end
            OP_AND: begin
                res    = acc & imm;
                acc_we = 1'b1;
            end
            OP_ADDI: begin
                sum         = {1'b0, acc} + {1'b0, imm};
                {cout, res} = sum;
                acc_we      = 1'b1;
                c_we        = 1'b1;
            end
            OP_ADDX: begin
                sum         = {1'b0, mem} + {1'b0, acc};
                {cout, res} = sum;
                acc_we      = 1'b1;
                c_we        = 1'b1;
            end
            OP_SUB: begin
                sum         = {1'b0, mem} - {1'b0, acc};
                {cout, res} = sum;
                acc_we      = 1'b1;
                c_we        = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nibcore.sv
module nibcore
    import nibcore_pkg::*;
#(
    parameter int SEG_LEN = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       enter,
    input  logic [3:0] din,
    output logic [3:0] dout,
    output logic       halted,
    output logic       running,
    output logic       zflag,
    output logic       cflag
);
    core_t r_d, r_q;

    logic          im_we;
    logic [AW-1:0] im_waddr;
    logic [IW-1:0] im_wdata, im_rdata;
    logic [DW-1:0] alu_res;
    logic          alu_cout, alu_acc_we, alu_c_we;
    logic [3:0]    op;
    logic [DW-1:0] arg;

    assign op  = r_q.ir[IW-1:DW];
    assign arg = r_q.ir[DW-1:0];

    nibcore_loader #(.SEG_LEN(SEG_LEN)) u_loader (
        .clk(clk), .rst_n(rst_n), .restart(restart), .enter(enter), .din(din),
        .we(im_we), .waddr(im_waddr), .wdata(im_wdata)
    );

    nibcore_imem u_imem (
        .clk(clk), .rst_n(rst_n), .we(im_we), .waddr(im_waddr), .wdata(im_wdata),
        .raddr(r_q.pc), .rdata(im_rdata)
    );

    nibcore_alu u_alu (
        .op(op), .acc(r_q.acc), .mem(r_q.opnd), .imm(arg),
        .res(alu_res), .cout(alu_cout), .acc_we(alu_acc_we), .c_we(alu_c_we)
    );

    always_comb begin
        r_d = r_q;
        if (restart) begin
            r_d.st     = S_LOAD;
            r_d.pc     = '0;
            r_d.halted = 1'b0;
        end else begin
            case (r_q.st)
                S_LOAD:   r_d.st = S_FETCH;
                S_FETCH: begin
                    r_d.ir = im_rdata;
                    r_d.st = S_DECODE;
                end
                S_DECODE: begin
                    r_d.opnd = (op == OP_ADDX) ? r_q.dm[r_q.ix] : r_q.dm[arg];
                    r_d.st   = S_EXEC;
                end
                S_EXEC: begin
                    r_d.st = S_FETCH;
                    r_d.pc = r_q.pc + 1'b1;
                    if (alu_acc_we) begin
                        r_d.acc = alu_res;
                        r_d.z   = (alu_res == '0);
                    end
                    if (alu_c_we) r_d.c = alu_cout;
                    case (op)
                        OP_HALT: begin
                            r_d.st     = S_STOP;
                            r_d.pc     = r_q.pc;
                            r_d.halted = 1'b1;
                        end
                        OP_RIP: begin
                            r_d.st = S_IDLE;
                            r_d.pc = '0;
                        end
                        OP_WO:   r_d.dout = r_q.acc;
                        OP_BNEZ: if (r_q.acc != '0) r_d.pc = arg;
                        OP_ST:   r_d.dm[arg] = r_q.acc;
                        OP_LDX:  r_d.ix = r_q.opnd;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
            r_q.z  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout    = r_q.dout;
    assign halted  = r_q.halted;
    assign running = (r_q.st == S_FETCH) || (r_q.st == S_DECODE) || (r_q.st == S_EXEC);
    assign zflag   = r_q.z;
    assign cflag   = r_q.c;

    assert_restart_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!running && !halted && r_q.pc == '0));
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !restart) |=> (halted && !running));
    assert_halt_not_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(halted && running));
    assert_dout_only_by_wo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != S_EXEC) |=> $stable(dout));
    assert_zero_tracks_acc_R13: assert property (@(posedge clk) disable iff (!rst_n)
        zflag == (r_q.acc == '0));
    assert_carry_kept_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_EXEC && !restart && (op == OP_LD || op == OP_AND)) |=> $stable(cflag));
endmodule

// File: tb/nibcore_bench.sv
module nibcore_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       enter = 1'b0;
    logic [3:0] din = 4'h0;
    logic [3:0] dout;
    logic       halted, running, zflag, cflag;

    always #5 clk = ~clk;

    nibcore u_nibcore (
        .clk(clk), .rst_n(rst_n), .restart(restart), .enter(enter), .din(din),
        .dout(dout), .halted(halted), .running(running), .zflag(zflag), .cflag(cflag)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    int wd = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 load, 2 run, 3 stopped
    int m_st = 0, m_cyc = 0, m_pc = 0, m_acc = 0, m_ix = 0, m_dout = 0;
    int m_z = 1, m_c = 0, m_halt = 0, m_ptr = 0, m_hi = 0;
    int m_dm[16];
    int m_im[16];
    bit m_second = 0, m_en_prev = 0;

    task automatic set_acc(int v);
        m_acc = v & 15;
        m_z   = (m_acc == 0) ? 1 : 0;
    endtask

    task automatic execute(int ins);
        int op = ins >> 4;
        int k  = ins & 15;
        int t;
        int nxt = (m_pc + 1) % 16;
        m_cyc = 0;
        case (op)
            0: begin m_halt = 1; m_st = 3; nxt = m_pc; end
            1: begin m_st = 0; nxt = 0; end
            2: m_dout = m_acc;
            3: if (m_acc != 0) nxt = k;
            4: set_acc(m_dm[k]);
            5: m_dm[k] = m_acc;
            7: m_ix = m_dm[k];
            8: begin t = m_dm[m_ix] + m_acc; m_c = (t > 15); set_acc(t); end
            9: set_acc(m_acc & k);
            10: begin t = m_acc + k; m_c = (t > 15); set_acc(t); end
            15: begin t = m_dm[k] - m_acc; m_c = (t < 0); set_acc(t + 16); end
            default: ;
        endcase
        m_pc = nxt;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cyc = 0; m_pc = 0; m_acc = 0; m_ix = 0; m_dout = 0;
            m_z = 1; m_c = 0; m_halt = 0; m_ptr = 0; m_hi = 0;
            m_second = 0; m_en_prev = 0;
            foreach (m_dm[i]) m_dm[i] = 0;
            foreach (m_im[i]) m_im[i] = 0;
        end else begin
            if (restart) begin
                if (enter && !m_en_prev) begin
                    if (!m_second) begin
                        m_hi = din; m_second = 1;
                    end else begin
                        m_second = 0;
                        if (m_ptr < 10) begin
                            m_im[m_ptr] = m_hi * 16 + din;
                            m_ptr++;
                        end
                    end
                end
            end else begin
                m_second = 0; m_ptr = 0;
            end
            m_en_prev = enter;
            if (restart) begin
                m_st = 1; m_pc = 0; m_halt = 0; m_cyc = 0;
            end else if (m_st == 1) begin
                m_st = 2; m_cyc = 0;
            end else if (m_st == 2) begin
                if (m_cyc == 2) execute(m_im[m_pc]);
                else m_cyc++;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R9",  "dout",    dout,    m_dout);
            check("R10", "halted",  halted,  m_halt);
            check("R4",  "running", running, (m_st == 2) ? 1 : 0);
            check("R13", "zflag",   zflag,   m_z);
            check("R6",  "cflag",   cflag,   m_c);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 100000) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=busy expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_nib(logic [3:0] v);
        @(negedge clk);
        din   = v;
        enter = 1'b1;
        cycles(2);
        enter = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input logic [7:0] p[$]);
        @(negedge clk);
        restart = 1'b1;
        cycles(2);
        foreach (p[i]) begin
            send_nib(p[i][7:4]);
            send_nib(p[i][3:0]);
        end
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic run_to_stop();
        int n = 0;
        cycles(3);
        while (running && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("R4", "program finished", running, 0);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset dout",    dout,    0);
        check("R1", "reset halted",  halted,  0);
        check("R1", "reset running", running, 0);
        check("R1", "reset zflag",   zflag,   1);
        check("R1", "reset cflag",   cflag,   0);
        cmp_on = 1'b1;

        // addi, st, nop, reversed sub with borrow, wo, halt
        load('{8'hA5, 8'h53, 8'hA9, 8'h60, 8'hF3, 8'h20, 8'h00});
        run_to_stop();
        check("R2", "loaded program output", dout, 7);
        check("R6", "sub borrow", cflag, 1);
        check("R12", "nop kept acc path", dout, 7);
        check("R10", "halted after halt", halted, 1);

        // and 0, indexed load and add, nop, wo, rip
        load('{8'h90, 8'hA2, 8'h54, 8'hA4, 8'h52, 8'h74, 8'h80, 8'hB5, 8'h20, 8'h10});
        run_to_stop();
        check("R7", "indexed sum", dout, 12);
        check("R11", "rip not halted", halted, 0);
        check("R11", "rip stops", running, 0);

        // countdown loop on preserved DM[3]
        load('{8'h43, 8'hAF, 8'h53, 8'h31, 8'hC0, 8'hD0, 8'hE0, 8'h20, 8'h00});
        run_to_stop();
        check("R8", "loop exit output", dout, 0);
        check("R5", "zero after loop", zflag, 1);
        check("R6", "carry from addi", cflag, 1);

        // eleven instructions: the extra wo must be dropped
        load('{8'hA1, 8'hA1, 8'hA1, 8'hA1, 8'hA1, 8'hA1, 8'hA1, 8'hA1, 8'hA1, 8'hA1, 8'h20});
        run_to_stop();
        check("R3", "overflow instruction ignored", dout, 0);
        check("R3", "halt at address 10", halted, 1);
        check("R13", "zflag after acc 10", zflag, 0);

        // restart colliding with each instruction phase
        for (int off = 0; off < 3; off++) begin
            load('{8'hA1, 8'h30});
            cycles(10 + off);
            @(negedge clk);
            restart = 1'b1;
            @(negedge clk);
            check("R4", "restart stops running", running, 0);
            check("R4", "restart clears halted", halted, 0);
        end
        load('{8'h20, 8'h00});
        run_to_stop();
        check("R10", "final halt", halted, 1);

        cmp_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule